// File: doc/BRIEF.md
# UART Receive FIFO with Trigger Level and Character Timeout

This block is the receive side storage of a 16550-style UART. A deserializer hands it one received byte per strobe, or a break event, and the host side pops bytes through a receive buffer read port. In FIFO mode up to `DEPTH` bytes are queued. In holding mode the block keeps a single byte. The block maintains the data-ready, overrun and break status bits, and it raises a timeout-pending flag when the queue holds data that nobody has read for a number of character times.

A write to the FIFO control byte chooses the mode and the interrupt trigger level, and it can flush the queue. The block does not compare the fill count against the trigger level and does not encode interrupts. It presents the fill count and the decoded trigger level to the logic that does. The character time is not derived here: it arrives as a one-cycle `char_tick` pulse.

Top module: `uart_rxq`

## Requirements
- R1: After reset, fill_count is 0, data_ready, overrun, brk_flag and timeout_pend are all 0, fifo_on is 0 (holding mode), trig_level is 1 and rd_data is 0x00.
- R2: On a control write, fcr_wdata[7:6] selects trig_level: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14. fcr_wdata[0] sets fifo_on.
- R3: In FIFO mode, received bytes leave in arrival order. fill_count tracks the number of stored bytes (0 to DEPTH), and data_ready is 1 exactly when fill_count is nonzero.
- R4: In FIFO mode, host_rd on an empty queue presents rd_data 0x00 and changes no count or flag.
- R5: In FIFO mode, a byte that arrives while the queue is full without a read in the same cycle is dropped and sets overrun. The stored bytes are kept unchanged.
- R6: In FIFO mode, when a read and a receive occur in the same cycle on a full queue, the read is served first and the new byte is stored, without overrun.
- R7: A break event stores a 0x00 byte under the same full-queue rule as R5, and it sets brk_flag and data_ready even when that byte is dropped.
- R8: In FIFO mode, every received byte or break restarts a timeout of TO_CHARS (4) char_tick pulses. On the last of these pulses, if the queue is not empty, timeout_pend is set. The counter then stays idle until the next restart. A restart in the same cycle as a tick takes precedence. In holding mode, timeout_pend stays 0.
- R9: host_rd clears timeout_pend. A read that leaves data in the queue restarts the timeout. A read that empties the queue clears data_ready and brk_flag and stops the timeout.
- R10: A control write with fcr_wdata[1] set, or with fcr_wdata[0] different from fifo_on, empties the queue, clears data_ready, brk_flag and timeout_pend, stops the timeout and discards any byte received in that cycle.
- R11: In holding mode, each received byte replaces the held byte and sets data_ready. If data_ready was already set and no read occurs in the same cycle, overrun is set. host_rd presents the held byte and clears data_ready and brk_flag. fill_count stays 0.
- R12: lsr_rd clears brk_flag and overrun. A break or overrun event in the same cycle takes precedence, so its flag is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: rx_data holds a received byte |
| rx_data | input | DW | Received byte |
| rx_break | input | 1 | One-cycle strobe: a break was received (takes precedence over rx_valid) |
| char_tick | input | 1 | One-cycle pulse per character time |
| host_rd | input | 1 | Host read of the receive buffer |
| rd_data | output | DW | Byte returned to the host, valid in the cycle of host_rd |
| lsr_rd | input | 1 | Host read of the line status, clears break and overrun |
| fcr_wr | input | 1 | Write strobe for the FIFO control byte |
| fcr_wdata | input | 8 | FIFO control byte: [0] enable, [1] flush, [7:6] trigger select |
| fifo_on | output | 1 | FIFO mode active |
| trig_level | output | $clog2(DEPTH+1) | Selected trigger level in bytes |
| fill_count | output | $clog2(DEPTH+1) | Number of stored bytes |
| data_ready | output | 1 | Receive data available |
| overrun | output | 1 | A byte was lost |
| brk_flag | output | 1 | A break was received |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
rd_data is combinational from the head entry or the held byte, so it is due in the same cycle as host_rd. The bench captures it one time step after driving the read, before the clock edge. fill_count and every status flag are registered and change on the edge that ends the stimulus cycle. The bench drives each stimulus for exactly one cycle starting at a falling edge, then samples these outputs at the next falling edge. The timeout is counted in ticks rather than cycles: timeout_pend is due at the edge that takes the fourth tick after the last restart, and the bench checks it both after the third tick, where it must still be clear, and after the fourth.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

   // Trigger select code carried in control bits 7:6
   typedef enum logic [1:0] {
      TRIG_ONE      = 2'b00,
      TRIG_FOUR     = 2'b01,
      TRIG_EIGHT    = 2'b10,
      TRIG_FOURTEEN = 2'b11
   } trig_sel_e;

   function automatic int unsigned trig_bytes(trig_sel_e sel);
      case (sel)
         TRIG_ONE:   return 1;
         TRIG_FOUR:  return 4;
         TRIG_EIGHT: return 8;
         default:    return 14;
      endcase
   endfunction

endpackage

// File: rtl/rxq_store.sv
// Circular byte store with occupancy count
module rxq_store #(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         push,
   input  logic                         pop,
   input  logic [DW-1:0]                wdata,
   output logic [DW-1:0]                head,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         full,
   output logic                         empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [DW-1:0] ent [DEPTH];

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ent[gi] <= '0;
            else if (push && (wr_ptr == AW'(gi)))
               ent[gi] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + AW'(1);
         if (pop)  rd_ptr <= rd_ptr + AW'(1);
         count <= count + CW'(push) - CW'(pop);
      end
   end

   assign head  = ent[rd_ptr];
   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);

endmodule

// File: rtl/rxq_timeout.sv
// Character-time watchdog: fires once after LIMIT ticks without restart
module rxq_timeout #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic stop,
   input  logic tick,
   output logic fire
);
   localparam int TW = $clog2(LIMIT+1);

   logic [TW-1:0] tcnt_q;
   logic          armed_q;
   logic          last_tick;

   assign last_tick = (tcnt_q == TW'(LIMIT-1));
   assign fire      = armed_q && tick && last_tick && !stop && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt_q  <= '0;
         armed_q <= 1'b0;
      end else if (stop) begin
         armed_q <= 1'b0;
      end else if (restart) begin
         tcnt_q  <= '0;
         armed_q <= 1'b1;
      end else if (tick && armed_q) begin
         tcnt_q <= tcnt_q + TW'(1);
         if (last_tick) armed_q <= 1'b0;
      end
   end

endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
   import uart_rxq_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int DW       = 8,
   parameter int TO_CHARS = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rx_valid,
   input  logic [DW-1:0]               rx_data,
   input  logic                        rx_break,
   input  logic                        char_tick,
   input  logic                        host_rd,
   output logic [DW-1:0]               rd_data,
   input  logic                        lsr_rd,
   input  logic                        fcr_wr,
   input  logic [7:0]                  fcr_wdata,
   output logic                        fifo_on,
   output logic [$clog2(DEPTH+1)-1:0]  trig_level,
   output logic [$clog2(DEPTH+1)-1:0]  fill_count,
   output logic                        data_ready,
   output logic                        overrun,
   output logic                        brk_flag,
   output logic                        timeout_pend
);
   localparam int CW        = $clog2(DEPTH+1);
   localparam int FCR_EN    = 0;
   localparam int FCR_FLUSH = 1;
   localparam int FCR_SEL   = 6;

   generate
      if (DEPTH < 14 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
         $error("uart_rxq: DEPTH must be a power of two of at least 14");
      end
      if (TO_CHARS < 1) begin : g_bad_to
         $error("uart_rxq: TO_CHARS must be at least 1");
      end
      if (DW < 1) begin : g_bad_dw
         $error("uart_rxq: DW must be positive");
      end
   endgenerate

   logic            fifo_en_q;
   trig_sel_e       trig_q;
   logic [DW-1:0]   hold_q;
   logic            dr_q, oe_q, bi_q, to_q;

   logic [DW-1:0]   head;
   logic [CW-1:0]   cnt;
   logic            full, empty;

   logic            clr, rx_evt, space;
   logic            push, pop, drop, last_pop;
   logic            hold_wr, hold_ovr;
   logic            to_restart, to_stop, to_fire;
   logic [DW-1:0]   rx_byte;

   // Flush on explicit request or on a change of mode
   assign clr     = fcr_wr && (fcr_wdata[FCR_FLUSH] || (fcr_wdata[FCR_EN] != fifo_en_q));
   assign rx_evt  = rx_valid || rx_break;
   assign rx_byte = rx_break ? '0 : rx_data;

   // FIFO mode: read served before receive
   assign pop      = host_rd && fifo_en_q && !empty && !clr;
   assign space    = !full || pop;
   assign push     = rx_evt && fifo_en_q && space && !clr;
   assign drop     = rx_evt && fifo_en_q && !space && !clr;
   assign last_pop = pop && (cnt == CW'(1)) && !push;

   // Holding mode
   assign hold_wr  = rx_evt && !fifo_en_q && !clr;
   assign hold_ovr = hold_wr && dr_q && !host_rd;

   assign to_restart = fifo_en_q && !clr && (rx_evt || (pop && !last_pop));
   assign to_stop    = clr || last_pop || !fifo_en_q;

   rxq_store #(
      .DEPTH (DEPTH),
      .DW    (DW)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .push  (push),
      .pop   (pop),
      .wdata (rx_byte),
      .head  (head),
      .count (cnt),
      .full  (full),
      .empty (empty)
   );

   rxq_timeout #(
      .LIMIT (TO_CHARS)
   ) u_timeout (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (to_restart),
      .stop    (to_stop),
      .tick    (char_tick),
      .fire    (to_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fifo_en_q <= 1'b0;
         trig_q    <= TRIG_ONE;
      end else if (fcr_wr) begin
         fifo_en_q <= fcr_wdata[FCR_EN];
         trig_q    <= trig_sel_e'(fcr_wdata[FCR_SEL+1:FCR_SEL]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (hold_wr)
         hold_q <= rx_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dr_q <= 1'b0;
      end else if (clr) begin
         dr_q <= 1'b0;
      end else if (fifo_en_q) begin
         if (push)          dr_q <= 1'b1;
         else if (last_pop) dr_q <= 1'b0;
      end else begin
         if (hold_wr)       dr_q <= 1'b1;
         else if (host_rd)  dr_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bi_q <= 1'b0;
      else if (clr)
         bi_q <= 1'b0;
      else if (rx_break)
         bi_q <= 1'b1;
      else if (lsr_rd)
         bi_q <= 1'b0;
      else if (fifo_en_q ? last_pop : host_rd)
         bi_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         oe_q <= 1'b0;
      else if (drop || hold_ovr)
         oe_q <= 1'b1;
      else if (lsr_rd)
         oe_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         to_q <= 1'b0;
      else if (clr || host_rd)
         to_q <= 1'b0;
      else if (to_fire && !empty)
         to_q <= 1'b1;
   end

   assign rd_data      = fifo_en_q ? (empty ? '0 : head) : hold_q;
   assign fifo_on      = fifo_en_q;
   assign trig_level   = CW'(trig_bytes(trig_q));
   assign fill_count   = cnt;
   assign data_ready   = dr_q;
   assign overrun      = oe_q;
   assign brk_flag     = bi_q;
   assign timeout_pend = to_q;

endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
   parameter int DEPTH = 16,
   parameter int DW    = 8
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        rx_valid,
   input logic                        rx_break,
   input logic                        host_rd,
   input logic [DW-1:0]               rd_data,
   input logic                        lsr_rd,
   input logic                        fcr_wr,
   input logic [7:0]                  fcr_wdata,
   input logic                        fifo_on,
   input logic [$clog2(DEPTH+1)-1:0]  trig_level,
   input logic [$clog2(DEPTH+1)-1:0]  fill_count,
   input logic                        data_ready,
   input logic                        overrun,
   input logic                        brk_flag,
   input logic                        timeout_pend
);
   localparam int CW = $clog2(DEPTH+1);

   p_trig_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trig_level == CW'(1) || trig_level == CW'(4) ||
      trig_level == CW'(8) || trig_level == CW'(14));

   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_count <= CW'(DEPTH));

   p_ready_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_on |-> (data_ready == (fill_count != '0)));

   p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_on && fill_count == '0 && host_rd) |-> (rd_data == '0));

   p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_on && fill_count == CW'(DEPTH) && rx_valid && !host_rd && !fcr_wr)
      |=> (overrun && fill_count == CW'(DEPTH)));

   p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fcr_wr && fcr_wdata[1])
      |=> (fill_count == '0 && !data_ready && !timeout_pend && !brk_flag));

   p_holding_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_on |-> (fill_count == '0 && !timeout_pend));

   p_lsr_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !rx_valid && !rx_break) |=> (!brk_flag && !overrun));

endmodule

bind uart_rxq uart_rxq_chk #(
   .DEPTH (DEPTH),
   .DW    (DW)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .rx_valid     (rx_valid),
   .rx_break     (rx_break),
   .host_rd      (host_rd),
   .rd_data      (rd_data),
   .lsr_rd       (lsr_rd),
   .fcr_wr       (fcr_wr),
   .fcr_wdata    (fcr_wdata),
   .fifo_on      (fifo_on),
   .trig_level   (trig_level),
   .fill_count   (fill_count),
   .data_ready   (data_ready),
   .overrun      (overrun),
   .brk_flag     (brk_flag),
   .timeout_pend (timeout_pend)
);

// File: tb/tb_uart_rxq.sv
module tb_uart_rxq;
   localparam int DEPTH = 16;
   localparam int DW    = 8;
   localparam int CW    = $clog2(DEPTH+1);

   // Vector: {op[2:0], data[7:0], exp_count[4:0], exp_flags{dr,oe,bi,to}[3:0], exp_rd[7:0]}
   localparam logic [2:0] OP_PUSH = 3'd1, OP_BRK = 3'd2, OP_READ = 3'd3,
                          OP_LSR = 3'd4, OP_FCR = 3'd5, OP_TICK = 3'd6;
   localparam int NVEC = 20;
   localparam logic [27:0] VEC [NVEC] = '{
      {3'd5, 8'h01, 5'd0, 4'b0000, 8'h00},
      {3'd1, 8'h11, 5'd1, 4'b1000, 8'h00},
      {3'd1, 8'h22, 5'd2, 4'b1000, 8'h00},
      {3'd3, 8'h00, 5'd1, 4'b1000, 8'h11},
      {3'd3, 8'h00, 5'd0, 4'b0000, 8'h22},
      {3'd3, 8'h00, 5'd0, 4'b0000, 8'h00},
      {3'd2, 8'h00, 5'd1, 4'b1010, 8'h00},
      {3'd4, 8'h00, 5'd1, 4'b1000, 8'h00},
      {3'd3, 8'h00, 5'd0, 4'b0000, 8'h00},
      {3'd1, 8'h5A, 5'd1, 4'b1000, 8'h00},
      {3'd6, 8'h00, 5'd1, 4'b1000, 8'h00},
      {3'd6, 8'h00, 5'd1, 4'b1000, 8'h00},
      {3'd6, 8'h00, 5'd1, 4'b1000, 8'h00},
      {3'd6, 8'h00, 5'd1, 4'b1001, 8'h00},
      {3'd6, 8'h00, 5'd1, 4'b1001, 8'h00},
      {3'd3, 8'h00, 5'd0, 4'b0000, 8'h5A},
      {3'd5, 8'hC1, 5'd0, 4'b0000, 8'h00},
      {3'd1, 8'h33, 5'd1, 4'b1000, 8'h00},
      {3'd5, 8'hC3, 5'd0, 4'b0000, 8'h00},
      {3'd3, 8'h00, 5'd0, 4'b0000, 8'h00}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_valid = 1'b0, rx_break = 1'b0, char_tick = 1'b0;
   logic          host_rd = 1'b0, lsr_rd = 1'b0, fcr_wr = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic [7:0]    fcr_wdata = '0;
   logic [DW-1:0] rd_data;
   logic          fifo_on, data_ready, overrun, brk_flag, timeout_pend;
   logic [CW-1:0] trig_level, fill_count;
   logic [DW-1:0] rd_cap;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   uart_rxq #(.DEPTH(DEPTH), .DW(DW), .TO_CHARS(4)) dut (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_break(rx_break), .char_tick(char_tick), .host_rd(host_rd),
      .rd_data(rd_data), .lsr_rd(lsr_rd), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
      .fifo_on(fifo_on), .trig_level(trig_level), .fill_count(fill_count),
      .data_ready(data_ready), .overrun(overrun), .brk_flag(brk_flag),
      .timeout_pend(timeout_pend)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int flags();
      return {data_ready, overrun, brk_flag, timeout_pend};
   endfunction

   // One stimulus cycle: drive at a falling edge, capture rd_data before the
   // rising edge, release at the next falling edge where registered outputs are sampled.
   task automatic cyc(input logic v, input logic [7:0] d, input logic b, input logic t,
                      input logic r, input logic l, input logic fw, input logic [7:0] fd);
      @(negedge clk);
      rx_valid = v; rx_data = d; rx_break = b; char_tick = t;
      host_rd = r; lsr_rd = l; fcr_wr = fw; fcr_wdata = fd;
      #1 rd_cap = rd_data;
      @(negedge clk);
      rx_valid = 0; rx_data = '0; rx_break = 0; char_tick = 0;
      host_rd = 0; lsr_rd = 0; fcr_wr = 0; fcr_wdata = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 count", fill_count, 0);
      chk("R1 flags", flags(), 0);
      chk("R1 fifo_on", fifo_on, 0);
      chk("R1 trig", trig_level, 1);
      chk("R1 rd_data", rd_data, 0);
      rst_n = 1'b1;

      // Table walk (R3 R4 R7 R8 R9 R10 R12)
      for (int i = 0; i < NVEC; i++) begin
         logic [2:0] op;
         logic [7:0] d;
         op = VEC[i][27:25];
         d  = VEC[i][24:17];
         cyc(op == OP_PUSH, d, op == OP_BRK, op == OP_TICK, op == OP_READ,
             op == OP_LSR, op == OP_FCR, d);
         chk($sformatf("R3 vec%0d count", i), fill_count, VEC[i][16:12]);
         chk($sformatf("R8 R9 vec%0d flags", i), flags(), VEC[i][11:8]);
         if (op == OP_READ)
            chk($sformatf("R4 vec%0d rd_data", i), rd_cap, VEC[i][7:0]);
      end

      // R2: trigger level decode, no flush while enable unchanged
      cyc(1, 8'h99, 0, 0, 0, 0, 0, 0);
      for (int s = 0; s < 4; s++) begin
         cyc(0, 0, 0, 0, 0, 0, 1, {s[1:0], 6'b000001});
         chk("R2 trig", trig_level, (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14);
      end
      chk("R2 no flush", fill_count, 1);
      cyc(0, 0, 0, 0, 1, 0, 0, 0);
      chk("R3 read back", rd_cap, 8'h99);

      // R3 R5: fill, then overflow
      for (int k = 0; k < DEPTH; k++) cyc(1, 8'h80 + 8'(k), 0, 0, 0, 0, 0, 0);
      chk("R3 full count", fill_count, DEPTH);
      cyc(1, 8'hEE, 0, 0, 0, 0, 0, 0);
      chk("R5 count kept", fill_count, DEPTH);
      chk("R5 overrun", overrun, 1);
      cyc(0, 0, 0, 0, 0, 1, 0, 0);
      chk("R12 lsr clears overrun", overrun, 0);
      // R7: break on full queue
      cyc(0, 0, 1, 0, 0, 0, 0, 0);
      chk("R7 break flags", flags(), 4'b1110);
      chk("R7 count", fill_count, DEPTH);
      cyc(0, 0, 0, 0, 0, 1, 0, 0);
      chk("R12 lsr clears both", flags(), 4'b1000);
      // R6: read and receive together on full queue
      cyc(1, 8'h77, 0, 0, 1, 0, 0, 0);
      chk("R6 rd_data", rd_cap, 8'h80);
      chk("R6 count", fill_count, DEPTH);
      chk("R6 no overrun", overrun, 0);
      for (int k = 1; k < DEPTH; k++) begin
         cyc(0, 0, 0, 0, 1, 0, 0, 0);
         chk("R5 order kept", rd_cap, 8'h80 + 8'(k));
      end
      cyc(0, 0, 0, 0, 1, 0, 0, 0);
      chk("R6 late byte", rd_cap, 8'h77);
      chk("R3 drained", flags(), 0);

      // R8 R9: read with data left restarts timeout
      cyc(1, 8'hA1, 0, 0, 0, 0, 0, 0);
      cyc(1, 8'hA2, 0, 0, 0, 0, 0, 0);
      repeat (3) cyc(0, 0, 0, 1, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 1, 0, 0, 0);
      chk("R9 read restarts", rd_cap, 8'hA1);
      repeat (3) cyc(0, 0, 0, 1, 0, 0, 0, 0);
      chk("R9 not yet", timeout_pend, 0);
      // R8: restart with tick in same cycle wins
      cyc(1, 8'hA3, 0, 1, 0, 0, 0, 0);
      chk("R8 restart wins", timeout_pend, 0);
      repeat (3) cyc(0, 0, 0, 1, 0, 0, 0, 0);
      chk("R8 three ticks", timeout_pend, 0);
      cyc(0, 0, 0, 1, 0, 0, 0, 0);
      chk("R8 fourth tick", timeout_pend, 1);

      // R10: disable toggles flush
      cyc(0, 0, 0, 0, 0, 0, 1, 8'h00);
      chk("R10 flush count", fill_count, 0);
      chk("R10 flush flags", flags(), 0);
      chk("R10 mode off", fifo_on, 0);
      repeat (4) cyc(0, 0, 0, 1, 0, 0, 0, 0);
      chk("R8 holding no timeout", timeout_pend, 0);
      // R10: byte in flush cycle discarded
      cyc(1, 8'h55, 0, 0, 0, 0, 1, 8'h01);
      chk("R10 discard count", fill_count, 0);
      chk("R10 discard dr", data_ready, 0);
      cyc(0, 0, 0, 0, 0, 0, 1, 8'h00);

      // R11: holding mode
      cyc(1, 8'h41, 0, 0, 0, 0, 0, 0);
      chk("R11 dr", data_ready, 1);
      cyc(1, 8'h42, 0, 0, 0, 0, 0, 0);
      chk("R11 overrun", overrun, 1);
      chk("R11 count", fill_count, 0);
      cyc(0, 0, 0, 0, 1, 0, 0, 0);
      chk("R11 rd_data", rd_cap, 8'h42);
      chk("R11 dr cleared", data_ready, 0);
      cyc(0, 0, 0, 0, 0, 1, 0, 0);
      cyc(1, 8'h44, 0, 0, 0, 0, 0, 0);
      // R12: overrun in same cycle as lsr read stays set
      cyc(1, 8'h45, 0, 0, 0, 1, 0, 0);
      chk("R12 event wins", overrun, 1);
      cyc(0, 0, 0, 0, 1, 0, 0, 0);
      chk("R11 newest", rd_cap, 8'h45);

      finish_run();
   end
endmodule